// File: doc/BRIEF.md
# Dual-Mode DAC Input Register

This block is the digital front end of a 16/18-bit digital-to-analog converter. It accepts a code in one of two ways. It can take two 8-bit bytes on a shared bus, or it can take a serial bit stream on one pin of that same bus. The code first goes into a first-rank register. A level-sensitive load strobe then passes it into a second-rank DAC latch, and that latch drives the converter code. Several converters can share one select and data line: each DAC can be updated on its own load strobe, or all of them at once.

The mode pin decides what the low bus pins mean. In byte mode they carry data, and two enables steer the byte into the upper or lower half of the 16-bit word. In serial mode, bus bit 0 is the serial input, bus bit 1 sets the bit order and bus bit 2 sets the word length. The first rank then works as a shift register. The bit it is about to lose is shown on a serial output, which feeds the next device in a chain.

A clear input forces the DAC latch to negative full scale or to midscale, chosen by a polarity pin, and leaves the first rank alone. All pins are sampled on a free-running system clock. A select strobe counts as an event only on the clock where it is first seen high.

Top module: `dual_mode_dac_input`

## Requirements
- R1: The first rank changes only on the clock where `sel_strobe` is first sampled high after being low. Holding the strobe high, or changing the bus while the strobe stays low, changes nothing.
- R2: In byte mode (`ser_mode_n` = 1), a capture with `hi_en` = 1 writes the bus into word bits 15:8, and one with `lo_en` = 1 writes it into bits 7:0. A half whose enable is low keeps its value. The two halves may be written in either order.
- R3: In serial mode (`ser_mode_n` = 0), `data_bus[0]` is the serial input, `data_bus[1]` = 1 selects MSB-first, and `data_bus[2]` = 1 selects an 18-bit word (0 selects 16 bits). `hi_en`, `lo_en` and `data_bus[7:3]` have no effect.
- R4: MSB-first: each capture shifts the active word toward its top and puts the new bit at bit 0. `ser_out` shows the top bit of the active length (bit 17 or bit 15).
- R5: LSB-first: each capture puts the new bit at the top bit of the active length and shifts toward bit 0. `ser_out` shows bit 0.
- R6: A 16-bit word (byte mode, or 16-bit serial) appears on `dac_code` left-justified, as word × 4, with bits 1:0 zero. An 18-bit serial word fills all 18 bits.
- R7: While `load_strobe` is high and `clear` is low, `dac_code` takes the first-rank word one clock later. While `load_strobe` is low, `dac_code` holds its value.
- R8: While `clear` is high, `dac_code` becomes 0x00000 if `clear_mid` = 0, or 0x20000 if `clear_mid` = 1, one clock later, whatever `load_strobe` is. The first rank is kept: once `clear` falls with `load_strobe` high, the old word returns.
- R9: After reset, the first rank and `dac_code` are zero, and `ser_out` is 0.
- R10: In a daisy chain, while a new serial word is shifted in, `ser_out` presents the previous word's bits in the order they entered, one per capture.

Ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_strobe | input | 1 | Select strobe; its rising edge captures data |
| ser_mode_n | input | 1 | 0 = serial mode, 1 = byte mode |
| hi_en | input | 1 | Byte mode: write upper half |
| lo_en | input | 1 | Byte mode: write lower half |
| data_bus | input | 8 | Byte data, or serial in / bit order / word length |
| load_strobe | input | 1 | High: DAC latch follows first rank |
| clear | input | 1 | Level clear of the DAC latch |
| clear_mid | input | 1 | Clear target: 0 = zero code, 1 = midscale |
| dac_code | output | 18 | Converter code |
| ser_out | output | 1 | Serial output for daisy chaining |

## Verification
A wrong first-rank bit stays hidden until it is brought out. It shows on `dac_code` one clock after the load strobe passes the word, or on `ser_out` after as many serial captures as there are bits between that bit and the outgoing end. The bench therefore reads each loaded word through the DAC latch, and it checks `ser_out` before every shift of the next word. A wrong shift direction or length shows up within a single word. A clear that wrongly touches the first rank shows only when `clear` is released, so the value restored after a clear is compared against the word written before it.

// File: rtl/dac_in_pkg.sv
package dac_in_pkg;

    localparam int DEF_BUS_W   = 8;
    localparam int DEF_SHORT_W = 16;
    localparam int DEF_LONG_W  = 18;

    typedef enum logic {
        LOAD_SERIAL = 1'b0,
        LOAD_BYTES  = 1'b1
    } load_mode_e;

    typedef struct packed {
        logic long_word;
        logic msb_first;
        logic sin;
    } serial_cfg_t;

endpackage

// File: rtl/dac_in_strobe_edge.sv
module dac_in_strobe_edge (
    input  logic clk,
    input  logic rst,
    input  logic sel,
    output logic cap
);
    logic sel_q;

    always_ff @(posedge clk) begin
        if (rst) sel_q <= 1'b0;
        else     sel_q <= sel;
    end

    assign cap = sel & ~sel_q;

    // R1
    single_capture_chk: assert property (@(posedge clk) disable iff (rst)
        cap |=> !cap);

endmodule

// File: rtl/dac_in_first_rank.sv
module dac_in_first_rank
    import dac_in_pkg::*;
#(
    parameter int BUS_W   = DEF_BUS_W,
    parameter int SHORT_W = DEF_SHORT_W,
    parameter int LONG_W  = DEF_LONG_W,
    localparam int LANES  = SHORT_W / BUS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap,
    input  load_mode_e        mode,
    input  serial_cfg_t       cfg,
    input  logic [LANES-1:0]  byte_en,
    input  logic [BUS_W-1:0]  bus,
    output logic [LONG_W-1:0] word,
    output logic              sout
);
    logic [LONG_W-1:0] word_q;
    logic [LONG_W-1:0] word_nxt;
    logic [LONG_W-1:0] ser_nxt;
    logic [LONG_W-1:0] byte_nxt;
    logic [LANES-1:0][BUS_W-1:0] lanes;
    logic sin_w, msb_w, long_w;

    assign sin_w  = cfg.sin;
    assign msb_w  = cfg.msb_first;
    assign long_w = cfg.long_word;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lanes[g] = byte_en[g] ? bus : word_q[g*BUS_W +: BUS_W];
    end

    assign byte_nxt = {word_q[LONG_W-1:SHORT_W], lanes};

    always_comb begin
        ser_nxt = word_q;
        if (long_w) begin
            ser_nxt = msb_w ? {word_q[LONG_W-2:0], sin_w}
                            : {sin_w, word_q[LONG_W-1:1]};
        end else begin
            ser_nxt[SHORT_W-1:0] = msb_w ? {word_q[SHORT_W-2:0], sin_w}
                                         : {sin_w, word_q[SHORT_W-1:1]};
        end
    end

    always_comb begin
        word_nxt = word_q;
        if (cap) word_nxt = (mode == LOAD_SERIAL) ? ser_nxt : byte_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) word_q <= '0;
        else     word_q <= word_nxt;
    end

    always_comb begin
        if (!msb_w)      sout = word_q[0];
        else if (long_w) sout = word_q[LONG_W-1];
        else             sout = word_q[SHORT_W-1];
    end

    assign word = word_q;

    // R1
    no_capture_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cap |=> $stable(word_q));
    // R2
    lane_keep_chk: assert property (@(posedge clk) disable iff (rst)
        cap && mode == LOAD_BYTES && !byte_en[0]
        |=> word_q[BUS_W-1:0] == $past(word_q[BUS_W-1:0]));
    // R4
    msb_entry_chk: assert property (@(posedge clk) disable iff (rst)
        cap && mode == LOAD_SERIAL && msb_w |=> word_q[0] == $past(sin_w));
    // R5
    lsb_entry_chk: assert property (@(posedge clk) disable iff (rst)
        cap && mode == LOAD_SERIAL && !msb_w && long_w
        |=> word_q[LONG_W-1] == $past(sin_w));

endmodule

// File: rtl/dac_in_second_rank.sv
module dac_in_second_rank
    import dac_in_pkg::*;
#(
    parameter int SHORT_W = DEF_SHORT_W,
    parameter int LONG_W  = DEF_LONG_W,
    localparam int PAD    = LONG_W - SHORT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              clr,
    input  logic              clr_mid,
    input  load_mode_e        mode,
    input  logic              long_word,
    input  logic [LONG_W-1:0] word,
    output logic [LONG_W-1:0] code
);
    localparam logic [LONG_W-1:0] MID_CODE = {1'b1, {(LONG_W-1){1'b0}}};

    logic [LONG_W-1:0] code_q;
    logic [LONG_W-1:0] framed;
    logic full_len;

    assign full_len = (mode == LOAD_SERIAL) && long_word;
    assign framed   = full_len ? word : {word[SHORT_W-1:0], {PAD{1'b0}}};

    always_ff @(posedge clk) begin
        if (rst)       code_q <= '0;
        else if (clr)  code_q <= clr_mid ? MID_CODE : '0;
        else if (load) code_q <= framed;
    end

    assign code = code_q;

    // R8
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clr && !clr_mid |=> code_q == '0);
    // R8
    clear_mid_chk: assert property (@(posedge clk) disable iff (rst)
        clr && clr_mid |=> code_q == MID_CODE);
    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !clr && !load |=> $stable(code_q));
    // R6
    pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !clr && load && !full_len |=> code_q[PAD-1:0] == '0);

endmodule

// File: rtl/dual_mode_dac_input.sv
module dual_mode_dac_input
    import dac_in_pkg::*;
#(
    parameter int BUS_W   = DEF_BUS_W,
    parameter int SHORT_W = DEF_SHORT_W,
    parameter int LONG_W  = DEF_LONG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_strobe,
    input  logic              ser_mode_n,
    input  logic              hi_en,
    input  logic              lo_en,
    input  logic [BUS_W-1:0]  data_bus,
    input  logic              load_strobe,
    input  logic              clear,
    input  logic              clear_mid,
    output logic [LONG_W-1:0] dac_code,
    output logic              ser_out
);
    logic              cap;
    load_mode_e        mode;
    serial_cfg_t       cfg;
    logic [LONG_W-1:0] word;

    assign mode          = ser_mode_n ? LOAD_BYTES : LOAD_SERIAL;
    assign cfg.sin       = data_bus[0];
    assign cfg.msb_first = data_bus[1];
    assign cfg.long_word = data_bus[2];

    dac_in_strobe_edge i_edge (
        .clk (clk),
        .rst (rst),
        .sel (sel_strobe),
        .cap (cap)
    );

    dac_in_first_rank #(
        .BUS_W   (BUS_W),
        .SHORT_W (SHORT_W),
        .LONG_W  (LONG_W)
    ) i_first (
        .clk     (clk),
        .rst     (rst),
        .cap     (cap),
        .mode    (mode),
        .cfg     (cfg),
        .byte_en ({hi_en, lo_en}),
        .bus     (data_bus),
        .word    (word),
        .sout    (ser_out)
    );

    dac_in_second_rank #(
        .SHORT_W (SHORT_W),
        .LONG_W  (LONG_W)
    ) i_second (
        .clk       (clk),
        .rst       (rst),
        .load      (load_strobe),
        .clr       (clear),
        .clr_mid   (clear_mid),
        .mode      (mode),
        .long_word (cfg.long_word),
        .word      (word),
        .code      (dac_code)
    );

    // R9
    reset_code_chk: assert property (@(posedge clk)
        rst |=> dac_code == '0);

endmodule

// File: tb/test_dual_mode_dac_input.sv
module test_dual_mode_dac_input;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel_strobe = 1'b0;
    logic        ser_mode_n = 1'b0;
    logic        hi_en = 1'b0;
    logic        lo_en = 1'b0;
    logic [7:0]  data_bus = 8'h00;
    logic        load_strobe = 1'b0;
    logic        clear = 1'b0;
    logic        clear_mid = 1'b0;
    logic [17:0] dac_code;
    logic        ser_out;

    int errs = 0;
    int checks = 0;
    int cyc = 0;

    dual_mode_dac_input i_dual_mode_dac_input (
        .clk(clk), .rst(rst), .sel_strobe(sel_strobe), .ser_mode_n(ser_mode_n),
        .hi_en(hi_en), .lo_en(lo_en), .data_bus(data_bus),
        .load_strobe(load_strobe), .clear(clear), .clear_mid(clear_mid),
        .dac_code(dac_code), .ser_out(ser_out)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            errs = errs + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errs = errs + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic strobe();
        sel_strobe = 1'b1;
        cycle();
        sel_strobe = 1'b0;
        cycle();
    endtask

    task automatic write_byte(input logic hi, input logic lo, input logic [7:0] v);
        ser_mode_n = 1'b1;
        hi_en = hi;
        lo_en = lo;
        data_bus = v;
        strobe();
        hi_en = 1'b0;
        lo_en = 1'b0;
    endtask

    function automatic logic [17:0] gen_word(input int k);
        return 18'((k * 32'h0002B5A3) ^ (k << 7) ^ 32'h00013579);
    endfunction

    // R3 R4 R5 R10: shift one word; optionally check the chained output
    task automatic shift_word(input logic [17:0] w, input logic msb, input logic l18,
                              input logic chain, input logic [17:0] prev);
        int n;
        n = l18 ? 18 : 16;
        ser_mode_n = 1'b0;
        for (int i = 0; i < n; i++) begin
            logic b;
            logic pb;
            b  = msb ? w[n-1-i] : w[i];
            pb = msb ? prev[n-1-i] : prev[i];
            hi_en = i[0];
            lo_en = ~i[1];
            data_bus = {5'(i * 7 + 3), l18, msb, b};
            @(negedge clk);
            if (chain) chk("R10 chained serial out", {17'b0, ser_out}, {17'b0, pb});
            strobe();
        end
        hi_en = 1'b0;
        lo_en = 1'b0;
        data_bus = {5'b0, l18, msb, 1'b0};
    endtask

    initial begin
        logic [17:0] prev;
        logic [17:0] w;
        repeat (3) cycle();
        rst = 1'b0;
        cycle();
        // R9 reset state
        chk("R9 reset code", dac_code, 18'h0);
        chk("R9 reset serial out", {17'b0, ser_out}, 18'h0);

        load_strobe = 1'b1;
        cycle();
        chk("R9 first rank zero", dac_code, 18'h0);

        // R2 R6 byte sweep, both orders
        for (int v = 0; v < 256; v++) begin
            logic [7:0] hb;
            logic [7:0] lb;
            hb = 8'(v);
            lb = 8'(v) ^ 8'hA5;
            if (v[0]) begin
                write_byte(1'b1, 1'b0, hb);
                write_byte(1'b0, 1'b1, lb);
            end else begin
                write_byte(1'b0, 1'b1, lb);
                write_byte(1'b1, 1'b0, hb);
            end
            chk("R2 R6 byte word", dac_code, {hb, lb, 2'b00});
        end
        // R2 both enables together
        write_byte(1'b1, 1'b1, 8'h5C);
        cycle();
        chk("R2 both halves", dac_code, {16'h5C5C, 2'b00});
        // R2 only low half changes
        write_byte(1'b0, 1'b1, 8'h01);
        cycle();
        chk("R2 upper kept", dac_code, {16'h5C01, 2'b00});

        // R1 strobe held high: single capture
        ser_mode_n = 1'b1; hi_en = 1'b1; lo_en = 1'b1; data_bus = 8'h11;
        sel_strobe = 1'b1;
        cycle();
        data_bus = 8'h22;
        cycle();
        cycle();
        sel_strobe = 1'b0;
        cycle();
        chk("R1 held strobe single capture", dac_code, {16'h1111, 2'b00});
        data_bus = 8'h33;
        cycle();
        cycle();
        chk("R1 bus change without strobe", dac_code, {16'h1111, 2'b00});
        hi_en = 1'b0; lo_en = 1'b0;

        // R7 hold while load low
        load_strobe = 1'b0;
        write_byte(1'b1, 1'b0, 8'hBE);
        write_byte(1'b0, 1'b1, 8'hEF);
        cycle();
        chk("R7 hold with load low", dac_code, {16'h1111, 2'b00});
        load_strobe = 1'b1;
        cycle();
        chk("R7 load passes word", dac_code, {16'hBEEF, 2'b00});

        // R8 clear
        clear = 1'b1; clear_mid = 1'b0;
        cycle();
        chk("R8 clear to zero", dac_code, 18'h00000);
        clear_mid = 1'b1;
        cycle();
        chk("R8 clear to midscale", dac_code, 18'h20000);
        clear = 1'b0; clear_mid = 1'b0;
        cycle();
        chk("R8 first rank kept", dac_code, {16'hBEEF, 2'b00});
        load_strobe = 1'b0;
        clear = 1'b1;
        cycle();
        clear = 1'b0;
        cycle();
        chk("R8 clear with load low", dac_code, 18'h0);
        load_strobe = 1'b1;
        cycle();
        chk("R8 restore on load", dac_code, {16'hBEEF, 2'b00});

        // R3 R4 R5 R6 R10 serial sweeps over all four configurations
        for (int m = 0; m < 4; m++) begin
            logic msb;
            logic l18;
            msb = m[0];
            l18 = m[1];
            prev = 18'h0;
            for (int k = 0; k < 20; k++) begin
                w = gen_word(k + m * 37);
                if (!l18) w[17:16] = 2'b00;
                shift_word(w, msb, l18, k > 0, prev);
                if (l18)
                    chk(msb ? "R4 R6 msb-first 18-bit" : "R5 R6 lsb-first 18-bit", dac_code, w);
                else
                    chk(msb ? "R4 R6 msb-first 16-bit" : "R5 R6 lsb-first 16-bit", dac_code, {w[15:0], 2'b00});
                chk(msb ? "R4 serial out top bit" : "R5 serial out bit 0",
                    {17'b0, ser_out}, {17'b0, msb ? (l18 ? w[17] : w[15]) : w[0]});
                prev = w;
            end
        end

        // R3 byte enables and upper bus bits ignored in serial mode (checked inside shift_word)
        shift_word(18'h0A5F0, 1'b1, 1'b0, 1'b0, 18'h0);
        chk("R3 enables ignored serial", dac_code, {16'hA5F0, 2'b00});

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule